// File: doc/BRIEF.md
# Branch History Target Table

This block is a small, fully associative prediction table for an instruction fetch stage. Each entry holds the full address of a branch, a two-bit saturating history counter for that branch, and the branch's last taken target. Every cycle the fetch address is compared against all valid entries in parallel. If an entry matches and its counter leans towards taken, the next fetch address is the stored target. In every other case the next fetch address is the current address plus one.

The execute stage reports each resolved branch on a resolve port. The report carries the branch address, its real outcome and target, and the prediction that fetch used for it. The table then trains the counter of the matching entry. A taken branch that found no entry gets a new entry, taken from a round-robin victim pointer. A branch that was predicted wrongly raises a one-cycle mispredict flag in the next cycle, together with the address fetch must restart from.

Because history follows each branch's own past outcomes, a loop-closing branch keeps its taken prediction through a single early exit. A miss always falls back to sequential fetch.

Top module: `btb_predictor`

## Requirements
- R1: After reset every entry is invalid, so any fetch address misses (pred_hit = 0, pred_taken = 0, pred_next_pc = fetch_pc + 1), and mispredict is 0.
- R2: The lookup is combinational in the same cycle. On a miss the prediction is not taken and pred_next_pc = fetch_pc + 1, modulo 2^AW.
- R3: A resolve with res_taken = 1 whose res_pc is not in the table allocates an entry with counter value 2 and the given target. From the next cycle on, a fetch of that address hits, predicts taken and gives pred_next_pc = res_target.
- R4: A resolve with res_taken = 0 whose res_pc is not in the table allocates nothing. The address still misses afterwards.
- R5: A resolve that hits trains the entry's 2-bit counter: taken adds one, saturating at 3, and not taken subtracts one, saturating at 0. Counter values 2 and 3 predict taken. Values 0 and 1 give a hit with pred_taken = 0 and pred_next_pc = fetch_pc + 1.
- R6: A taken resolve that hits replaces the stored target with res_target.
- R7: Allocation uses a round-robin pointer over the ENTRIES slots (default 8) that advances once per allocation and wraps. Allocation ENTRIES+1 after reset evicts the first entry that was allocated, and the other entries remain.
- R8: A resolve is mispredicted when res_taken differs from res_pred_taken, or when both are taken and res_target differs from res_pred_target. In the cycle after such a resolve, mispredict is 1 for exactly one cycle, with redirect_pc = res_target if taken and res_pc + 1 if not. A correctly predicted resolve leaves mispredict at 0.
- R9: When a lookup and an update of the same address fall in the same cycle, the lookup returns the table contents from before the update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_pc | input | AW | Current fetch address being looked up |
| pred_hit | output | 1 | A valid entry matches fetch_pc |
| pred_taken | output | 1 | Prediction is taken |
| pred_next_pc | output | AW | Predicted next fetch address |
| res_valid | input | 1 | A resolved branch is presented this cycle |
| res_pc | input | AW | Address of the resolved branch |
| res_taken | input | 1 | Real outcome of the resolved branch |
| res_target | input | AW | Real target of the resolved branch |
| res_pred_taken | input | 1 | Taken prediction that fetch used for this branch |
| res_pred_target | input | AW | Target that fetch used for this branch |
| mispredict | output | 1 | One-cycle flag: the previous resolve was mispredicted |
| redirect_pc | output | AW | Corrected next address, valid while mispredict is 1 |

## Verification
Lookup results are combinational. The bench drives fetch_pc on a falling edge and samples the prediction a few nanoseconds later, in the same cycle. A resolve changes table contents only at the next rising edge, so its effect on prediction is checked by a lookup after the following falling edge. The same timing applies to the same-cycle test: the miss is sampled before that edge and the hit after it. The mispredict flag and redirect address are registered, so they are sampled at the falling edge one cycle after the resolve was driven. The flag is checked again one cycle later to confirm that it has dropped.

// File: rtl/btb_pkg.sv
package btb_pkg;

   typedef enum logic [1:0] {
      UPD_IDLE  = 2'd0,
      UPD_TRAIN = 2'd1,
      UPD_ALLOC = 2'd2
   } upd_e;

   // Decide what a resolve does to the table.
   function automatic upd_e classify(input logic valid, input logic hit, input logic taken);
      upd_e act;
      act = UPD_IDLE;
      if (valid) begin
         if (hit)        act = UPD_TRAIN;
         else if (taken) act = UPD_ALLOC;
      end
      return act;
   endfunction

   // Misprediction test on a resolved branch.
   function automatic logic is_mispredicted(input logic taken, input logic pred_taken,
                                            input logic tgt_differs);
      return (taken != pred_taken) || (taken && tgt_differs);
   endfunction

endpackage

// File: rtl/btb_match.sv
module btb_match #(
   parameter int AW      = 16,
   parameter int ENTRIES = 8,
   localparam int IDX_W  = $clog2(ENTRIES)
) (
   input  logic [ENTRIES-1:0]         ent_valid,
   input  logic [ENTRIES-1:0][AW-1:0] ent_tag,
   input  logic [AW-1:0]              key,
   output logic [ENTRIES-1:0]         hitv,
   output logic                       hit,
   output logic [IDX_W-1:0]           idx
);

   for (genvar e = 0; e < ENTRIES; e++) begin : g_cmp
      assign hitv[e] = ent_valid[e] && (ent_tag[e] == key);
   end

   assign hit = |hitv;

   // Entries are unique, so an OR of the matching indices is the encoder.
   always_comb begin
      idx = '0;
      for (int e = 0; e < ENTRIES; e++) begin
         if (hitv[e]) idx = idx | IDX_W'(e);
      end
   end

endmodule

// File: rtl/btb_sat_ctr.sv
module btb_sat_ctr #(
   parameter int CNT_W = 2
) (
   input  logic [CNT_W-1:0] cnt,
   input  logic             taken,
   output logic [CNT_W-1:0] cnt_next,
   output logic             predict
);

   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
   localparam logic [CNT_W-1:0] CNT_MIN = '0;

   assign predict = cnt[CNT_W-1];

   always_comb begin
      cnt_next = cnt;
      if (taken) begin
         if (cnt != CNT_MAX) cnt_next = cnt + CNT_W'(1);
      end else begin
         if (cnt != CNT_MIN) cnt_next = cnt - CNT_W'(1);
      end
   end

endmodule

// File: rtl/btb_rr_ptr.sv
module btb_rr_ptr #(
   parameter int ENTRIES = 8,
   localparam int IDX_W  = $clog2(ENTRIES)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             advance,
   output logic [IDX_W-1:0] victim
);

   localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         victim <= '0;
      end else if (advance) begin
         victim <= (victim == LAST) ? '0 : victim + IDX_W'(1);
      end
   end

endmodule

// File: rtl/btb_predictor.sv
module btb_predictor #(
   parameter int AW              = 16,
   parameter int ENTRIES         = 8,
   parameter int CNT_W           = 2,
   parameter bit TARGET_ON_TRAIN = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [AW-1:0] fetch_pc,
   output logic          pred_hit,
   output logic          pred_taken,
   output logic [AW-1:0] pred_next_pc,
   input  logic          res_valid,
   input  logic [AW-1:0] res_pc,
   input  logic          res_taken,
   input  logic [AW-1:0] res_target,
   input  logic          res_pred_taken,
   input  logic [AW-1:0] res_pred_target,
   output logic          mispredict,
   output logic [AW-1:0] redirect_pc
);
   import btb_pkg::*;

   localparam int IDX_W = $clog2(ENTRIES);
   localparam logic [CNT_W-1:0] CNT_INIT = CNT_W'(1) << (CNT_W - 1);

   if (ENTRIES < 2) begin : g_bad_entries
      $error("btb_predictor: ENTRIES must be at least 2");
   end
   if (CNT_W < 1 || CNT_W > 4) begin : g_bad_cnt
      $error("btb_predictor: CNT_W must be in 1..4");
   end
   if (AW < 2) begin : g_bad_aw
      $error("btb_predictor: AW must be at least 2");
   end

   logic [ENTRIES-1:0]            ent_valid;
   logic [ENTRIES-1:0][AW-1:0]    ent_tag;
   logic [ENTRIES-1:0][AW-1:0]    ent_tgt;
   logic [ENTRIES-1:0][CNT_W-1:0] ent_cnt;
   logic [ENTRIES-1:0][CNT_W-1:0] ent_cnt_next;
   logic [ENTRIES-1:0]            ent_predict;

   logic [ENTRIES-1:0] fetch_hitv;
   logic               fetch_hit;
   logic [IDX_W-1:0]   fetch_idx;
   logic [ENTRIES-1:0] res_hitv;
   logic               res_hit;
   logic [IDX_W-1:0]   res_idx;
   logic [IDX_W-1:0]   victim;
   upd_e               action;

   // Fetch-side lookup port.
   btb_match #(.AW(AW), .ENTRIES(ENTRIES)) u_fetch_match (
      .ent_valid (ent_valid),
      .ent_tag   (ent_tag),
      .key       (fetch_pc),
      .hitv      (fetch_hitv),
      .hit       (fetch_hit),
      .idx       (fetch_idx)
   );

   // Resolve-side lookup port.
   btb_match #(.AW(AW), .ENTRIES(ENTRIES)) u_res_match (
      .ent_valid (ent_valid),
      .ent_tag   (ent_tag),
      .key       (res_pc),
      .hitv      (res_hitv),
      .hit       (res_hit),
      .idx       (res_idx)
   );

   assign action = classify(res_valid, res_hit, res_taken);

   btb_rr_ptr #(.ENTRIES(ENTRIES)) u_victim (
      .clk     (clk),
      .rst_n   (rst_n),
      .advance (action == UPD_ALLOC),
      .victim  (victim)
   );

   // Per-entry history counter and storage.
   for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
      logic do_train;
      logic do_alloc;
      logic tgt_write;

      btb_sat_ctr #(.CNT_W(CNT_W)) u_ctr (
         .cnt      (ent_cnt[e]),
         .taken    (res_taken),
         .cnt_next (ent_cnt_next[e]),
         .predict  (ent_predict[e])
      );

      assign do_train = (action == UPD_TRAIN) && (res_idx == IDX_W'(e));
      assign do_alloc = (action == UPD_ALLOC) && (victim == IDX_W'(e));

      if (TARGET_ON_TRAIN) begin : g_tgt_train
         assign tgt_write = do_alloc || (do_train && res_taken);
      end else begin : g_tgt_alloc_only
         assign tgt_write = do_alloc;
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            ent_valid[e] <= 1'b0;
            ent_tag[e]   <= '0;
            ent_cnt[e]   <= '0;
         end else if (do_alloc) begin
            ent_valid[e] <= 1'b1;
            ent_tag[e]   <= res_pc;
            ent_cnt[e]   <= CNT_INIT;
         end else if (do_train) begin
            ent_cnt[e]   <= ent_cnt_next[e];
         end
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            ent_tgt[e] <= '0;
         end else if (tgt_write) begin
            ent_tgt[e] <= res_target;
         end
      end
   end

   // Prediction output.
   logic          sel_predict;
   logic [AW-1:0] sel_target;
   logic [AW-1:0] seq_pc;

   assign sel_predict  = ent_predict[fetch_idx];
   assign sel_target   = ent_tgt[fetch_idx];
   assign seq_pc       = fetch_pc + AW'(1);
   assign pred_hit     = fetch_hit;
   assign pred_taken   = fetch_hit && sel_predict;
   assign pred_next_pc = pred_taken ? sel_target : seq_pc;

   // Misprediction report, registered one cycle after the resolve.
   logic          misp_now;
   logic [AW-1:0] fix_pc;

   assign misp_now = res_valid &&
                     is_mispredicted(res_taken, res_pred_taken, res_target != res_pred_target);
   assign fix_pc   = res_taken ? res_target : (res_pc + AW'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mispredict  <= 1'b0;
         redirect_pc <= '0;
      end else begin
         mispredict  <= misp_now;
         if (misp_now) redirect_pc <= fix_pc;
      end
   end

endmodule

// File: rtl/btb_predictor_chk.sv
module btb_predictor_chk #(
   parameter int AW      = 16,
   parameter int ENTRIES = 8
) (
   input logic               clk,
   input logic               rst_n,
   input logic [AW-1:0]      fetch_pc,
   input logic               pred_hit,
   input logic               pred_taken,
   input logic [AW-1:0]      pred_next_pc,
   input logic               res_valid,
   input logic [AW-1:0]      res_pc,
   input logic               res_taken,
   input logic [AW-1:0]      res_target,
   input logic               mispredict,
   input logic [AW-1:0]      redirect_pc,
   input logic [ENTRIES-1:0] fetch_hitv,
   input logic [ENTRIES-1:0] res_hitv
);

   // R2
   miss_sequential_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !pred_hit |-> (!pred_taken && pred_next_pc == fetch_pc + AW'(1)));

   // R3
   taken_needs_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pred_taken |-> pred_hit);

   // R3
   alloc_visible_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && res_taken && res_hitv == '0) |=>
         ((fetch_pc != $past(res_pc)) ||
          (pred_hit && pred_taken && pred_next_pc == $past(res_target))));

   // R7
   unique_fetch_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(fetch_hitv));

   // R7
   unique_res_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(res_hitv));

   // R8
   mispredict_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mispredict |-> $past(res_valid));

   // R8
   redirect_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mispredict |-> (redirect_pc == ($past(res_taken) ? $past(res_target)
                                                        : $past(res_pc) + AW'(1))));

endmodule

bind btb_predictor btb_predictor_chk #(.AW(AW), .ENTRIES(ENTRIES)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .fetch_pc     (fetch_pc),
   .pred_hit     (pred_hit),
   .pred_taken   (pred_taken),
   .pred_next_pc (pred_next_pc),
   .res_valid    (res_valid),
   .res_pc       (res_pc),
   .res_taken    (res_taken),
   .res_target   (res_target),
   .mispredict   (mispredict),
   .redirect_pc  (redirect_pc),
   .fetch_hitv   (fetch_hitv),
   .res_hitv     (res_hitv)
);

// File: tb/test_btb_predictor.sv
`timescale 1ns/1ps
module test_btb_predictor;
   localparam int AW = 16;
   localparam int N  = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [AW-1:0] fetch_pc = '0;
   logic          pred_hit, pred_taken;
   logic [AW-1:0] pred_next_pc;
   logic          res_valid = 1'b0;
   logic [AW-1:0] res_pc = '0;
   logic          res_taken = 1'b0;
   logic [AW-1:0] res_target = '0;
   logic          res_pred_taken = 1'b0;
   logic [AW-1:0] res_pred_target = '0;
   logic          mispredict;
   logic [AW-1:0] redirect_pc;

   int n_chk = 0;
   int n_bad = 0;
   bit finished = 1'b0;

   always #10 clk = ~clk;

   btb_predictor #(.AW(AW), .ENTRIES(N), .CNT_W(2)) i_btb_predictor (
      .clk(clk), .rst_n(rst_n), .fetch_pc(fetch_pc),
      .pred_hit(pred_hit), .pred_taken(pred_taken), .pred_next_pc(pred_next_pc),
      .res_valid(res_valid), .res_pc(res_pc), .res_taken(res_taken),
      .res_target(res_target), .res_pred_taken(res_pred_taken),
      .res_pred_target(res_pred_target),
      .mispredict(mispredict), .redirect_pc(redirect_pc)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n     = 1'b0;
      res_valid = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   // Lookup in the current cycle; outputs are combinational.
   task automatic lookup(input string req, input logic [AW-1:0] pc,
                         input logic eh, input logic et, input logic [AW-1:0] en);
      @(negedge clk);
      fetch_pc = pc;
      #2;
      chk({req, " hit"},   32'(pred_hit),     32'(eh));
      chk({req, " taken"}, 32'(pred_taken),   32'(et));
      chk({req, " next"},  32'(pred_next_pc), 32'(en));
   endtask

   // One resolve cycle; the mispredict flag is checked one cycle later.
   task automatic resolve(input string req, input logic [AW-1:0] pc, input logic tk,
                          input logic [AW-1:0] tgt, input logic ptk, input logic [AW-1:0] ptgt);
      logic          em;
      logic [AW-1:0] er;
      em = (tk != ptk) || (tk && tgt != ptgt);
      er = tk ? tgt : pc + AW'(1);
      @(negedge clk);
      res_valid = 1'b1; res_pc = pc; res_taken = tk;
      res_target = tgt; res_pred_taken = ptk; res_pred_target = ptgt;
      @(negedge clk);
      res_valid = 1'b0;
      #2;
      chk({req, " mispredict"}, 32'(mispredict), 32'(em));
      if (em) chk({req, " redirect"}, 32'(redirect_pc), 32'(er));
   endtask

   task automatic t_reset();
      lookup("R1 reset lookup", 16'h0100, 1'b0, 1'b0, 16'h0101);
      chk("R1 reset mispredict", 32'(mispredict), 32'd0);
   endtask

   task automatic t_miss();
      lookup("R2 miss", 16'h0234, 1'b0, 1'b0, 16'h0235);
      lookup("R2 miss wrap", 16'hFFFF, 1'b0, 1'b0, 16'h0000);
   endtask

   task automatic t_alloc();
      resolve("R3 alloc", 16'h0040, 1'b1, 16'h0800, 1'b0, 16'h0000);
      lookup("R3 alloc hit", 16'h0040, 1'b1, 1'b1, 16'h0800);
   endtask

   task automatic t_nt_miss();
      resolve("R4 nt", 16'h0050, 1'b0, 16'h0900, 1'b0, 16'h0000);
      lookup("R4 still miss", 16'h0050, 1'b0, 1'b0, 16'h0051);
   endtask

   task automatic t_counter();
      logic [AW-1:0] a = 16'h0060;
      logic [AW-1:0] t = 16'h0A00;
      resolve("R5 alloc", a, 1'b1, t, 1'b1, t);           // cnt 2
      resolve("R5 nt", a, 1'b0, t, 1'b1, t);              // cnt 1
      lookup("R5 cnt1", a, 1'b1, 1'b0, a + 16'd1);
      resolve("R5 t", a, 1'b1, t, 1'b0, t);               // cnt 2
      lookup("R5 cnt2", a, 1'b1, 1'b1, t);
      resolve("R5 t", a, 1'b1, t, 1'b1, t);               // cnt 3
      resolve("R5 t sat", a, 1'b1, t, 1'b1, t);           // cnt 3
      resolve("R5 nt", a, 1'b0, t, 1'b1, t);              // cnt 2
      lookup("R5 saturate high", a, 1'b1, 1'b1, t);
      resolve("R5 nt", a, 1'b0, t, 1'b1, t);              // cnt 1
      resolve("R5 nt", a, 1'b0, t, 1'b0, t);              // cnt 0
      resolve("R5 nt sat", a, 1'b0, t, 1'b0, t);          // cnt 0
      resolve("R5 t", a, 1'b1, t, 1'b0, t);               // cnt 1
      lookup("R5 from 0", a, 1'b1, 1'b0, a + 16'd1);
      resolve("R5 t", a, 1'b1, t, 1'b0, t);               // cnt 2
      lookup("R5 saturate low", a, 1'b1, 1'b1, t);
   endtask

   task automatic t_target();
      resolve("R6 alloc", 16'h0070, 1'b1, 16'h0B00, 1'b0, 16'h0000);
      resolve("R6 new target", 16'h0070, 1'b1, 16'h0C00, 1'b1, 16'h0B00);
      lookup("R6 target", 16'h0070, 1'b1, 1'b1, 16'h0C00);
   endtask

   task automatic t_mispredict();
      // R8 correctly predicted: no flag
      resolve("R8 correct", 16'h0040, 1'b1, 16'h0800, 1'b1, 16'h0800);
      // R8 wrong target
      resolve("R8 wrong target", 16'h0040, 1'b1, 16'h0880, 1'b1, 16'h0800);
      @(negedge clk); #2;
      chk("R8 one cycle", 32'(mispredict), 32'd0);
      // R8 predicted taken, went not taken
      resolve("R8 nt redirect", 16'h0040, 1'b0, 16'h0880, 1'b1, 16'h0880);
      @(negedge clk); #2;
      chk("R8 one cycle nt", 32'(mispredict), 32'd0);
   endtask

   task automatic t_same_cycle();
      @(negedge clk);
      fetch_pc = 16'h0090;
      res_valid = 1'b1; res_pc = 16'h0090; res_taken = 1'b1;
      res_target = 16'h0D00; res_pred_taken = 1'b1; res_pred_target = 16'h0D00;
      #2;
      chk("R9 same cycle old miss", 32'(pred_hit), 32'd0);
      chk("R9 same cycle next", 32'(pred_next_pc), 32'h0091);
      @(negedge clk);
      res_valid = 1'b0;
      #2;
      chk("R9 after edge hit", 32'(pred_hit), 32'd1);
      chk("R9 after edge next", 32'(pred_next_pc), 32'h0D00);
   endtask

   task automatic t_round_robin();
      do_reset();
      for (int i = 0; i <= N; i++) begin
         resolve("R7 fill", AW'(16'h1000 + i), 1'b1, AW'(16'h2000 + i), 1'b1, AW'(16'h2000 + i));
      end
      lookup("R7 evicted", 16'h1000, 1'b0, 1'b0, 16'h1001);
      for (int i = 1; i <= N; i++) begin
         lookup("R7 kept", AW'(16'h1000 + i), 1'b1, 1'b1, AW'(16'h2000 + i));
      end
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   endtask

   initial begin
      #200000;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      finish_run();
   end

   initial begin
      do_reset();
      t_reset();
      t_miss();
      t_alloc();
      t_nt_miss();
      t_counter();
      t_target();
      t_mispredict();
      t_same_cycle();
      t_round_robin();
      finish_run();
   end

endmodule